// File: doc/BRIEF.md
# BCD Timekeeping Counter Chain

This block keeps calendar time as a chain of packed-BCD counters: hundredths of a second, seconds, minutes, hours (24-hour), day of week, date, month and year. It is driven by a single-cycle `tick` enable at the crystal rate, 32,768 per second by default. A fractional divider turns those ticks into exactly one hundred hundredth-steps per second. Each carry ripples through every field in the same clock cycle as the tick that causes it.

Software loads the fields through a byte-wide write port addressed by field. Any write clears the hundredths field and restarts the divider, so a new time starts on a clean second boundary. The seconds byte also holds a halt flag that freezes the whole chain. The hours byte holds a century-enable flag and a century flag, and the century flag flips when the year wraps from 99 to 00. All fields are presented as registered BCD bytes.

Top module: `tod_chain`

## Requirements
- R1: After a synchronous reset, hundredths, seconds, minutes, hours and year read 00, day of week, date and month read 01, and the halt, century-enable and century flags read 0.
- R2: Without writes or halt, the n-th hundredth step counted from reset or from the last write happens on tick number ceil(n*TICK_HZ/100). It is visible the cycle after that tick. With `tick` low and no write, no field changes.
- R3: Any write, to any address, sets hundredths to 00 and restarts the divider phase. The data written to address 0 is ignored.
- R4: A write loads on the next edge: addr 1 bits 6:0 seconds and bit 7 halt; addr 2 bits 6:0 minutes; addr 3 bits 5:0 hours, bit 7 century-enable and bit 6 century; addr 4 bits 2:0 day of week; addr 5 bits 5:0 date; addr 6 bits 4:0 month; addr 7 year. Unused high bits read 0, and `hour_o` returns bits 7:6 as written.
- R5: While halt is 1, ticks are ignored and every field and the divider phase hold.
- R6: Hundredths count 00..99, seconds and minutes 00..59, and hours 00..23, in BCD. A field at or above its top value wraps to its bottom value and carries. The whole carry chain settles within the tick's own cycle.
- R7: When the year wraps 99 to 00, the century flag inverts if century-enable is 1. If century-enable is 0, the century flag holds.
- R8: Day of week counts 1..7 and wraps to 1. The hours wrap from 23 to 00 advances both day of week and date.
- R9: Date wraps to 01 after the month's last day (31; 30 for months 04, 06, 09, 11; February 29 when the BCD year is divisible by 4, else 28) and advances the month. Month wraps 12 to 01 and advances the year.
- R10: A write in the same cycle as a tick takes priority: that tick advances no field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle time-base enable |
| wr_en | input | 1 | Field write strobe |
| wr_addr | input | 3 | Field address 0..7 |
| wr_data | input | 8 | Field write data |
| hund_o | output | 8 | Hundredths of a second, BCD |
| sec_o | output | 8 | Halt flag and seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Century-enable, century flag, hours BCD |
| wday_o | output | 8 | Day of week 1..7 |
| date_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year, BCD |

## Verification
The hardest state to reach is a full cascade: one tick that rolls hundredths, seconds, minutes, hours, date, month and year together and flips the century flag. Getting there normally takes years of ticks. The bench overrides the tick rate to 250 per second. It then loads the fields to one second before the boundary under test: month ends in leap and common years, the year end with century-enable on and off, and a write landing on the carrying tick. Random stimulus adds writes biased toward top values, so that wraps keep occurring throughout a long mixed run.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int NFLD = 8;
  localparam int AW   = 3;
  localparam int DW   = 8;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = v + 8'd1;
    return r;
  endfunction

  // bottom value of each field
  function automatic logic [7:0] fld_lo(input int i);
    case (i)
      4, 5, 6: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  // top value of each field (date is replaced by the month table)
  function automatic logic [7:0] fld_hi(input int i);
    case (i)
      0, 7:    return 8'h99;
      1, 2:    return 8'h59;
      3:       return 8'h23;
      4:       return 8'h07;
      6:       return 8'h12;
      default: return 8'h31;
    endcase
  endfunction

  // bits kept on a load; hundredths always loads zero
  function automatic logic [7:0] fld_mask(input int i);
    case (i)
      0:       return 8'h00;
      1, 2:    return 8'h7F;
      3, 5:    return 8'h3F;
      4:       return 8'h07;
      6:       return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  // index of the field whose carry advances field i; -1 means the divider
  function automatic int fld_src(input int i);
    case (i)
      0:       return -1;
      4, 5:    return 3;
      6:       return 5;
      7:       return 6;
      default: return i - 1;
    endcase
  endfunction

  // BCD year divisible by 4: (ones + 10*tens) mod 4 == (ones + 2*tens) mod 4
  function automatic logic leap_yr(input logic [7:0] y);
    logic [1:0] s;
    s = y[1:0] + {y[4], 1'b0};
    return (s == 2'd0);
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] m, input logic leap);
    case (m)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/tod_divider.sv
module tod_divider #(
  parameter int TICK_HZ = 32768,
  parameter int STEP    = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic tick_i,
  input  logic run_i,
  output logic pulse_o
);
  localparam int ACC_W = $clog2(TICK_HZ + STEP) + 1;
  localparam logic [ACC_W-1:0] STEP_V = ACC_W'(STEP);
  localparam logic [ACC_W-1:0] WRAP_V = ACC_W'(TICK_HZ);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum;
  logic             adv;

  assign adv     = tick_i & run_i;
  assign sum     = acc_q + STEP_V;
  assign pulse_o = adv && (sum >= WRAP_V);

  always_ff @(posedge clk) begin
    if (rst || clr_i)  acc_q <= '0;
    else if (pulse_o)  acc_q <= sum - WRAP_V;
    else if (adv)      acc_q <= sum;
  end
endmodule

// File: rtl/tod_field.sv
module tod_field #(
  parameter logic [7:0] LO   = 8'h00,
  parameter logic [7:0] MASK = 8'hFF
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inc_i,
  input  logic       ld_i,
  input  logic [7:0] ld_d_i,
  input  logic [7:0] hi_i,
  output logic [7:0] q_o,
  output logic       carry_o
);
  import tod_pkg::*;

  logic [7:0] q;
  logic       at_top;

  assign at_top  = (q >= hi_i);
  assign carry_o = inc_i && at_top;
  assign q_o     = q;

  always_ff @(posedge clk) begin
    if (rst)        q <= LO;
    else if (ld_i)  q <= ld_d_i & MASK;
    else if (inc_i) q <= at_top ? LO : bcd_inc(q);
  end
endmodule

// File: rtl/tod_chain.sv
module tod_chain #(
  parameter int TICK_HZ = 32768
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] hund_o,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] wday_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o
);
  import tod_pkg::*;

  localparam int SUB_STEPS = 100;
  localparam int A_SEC  = 1;
  localparam int A_HOUR = 3;
  localparam int I_DATE = 5;
  localparam int I_YEAR = 7;

  logic             halt_q;
  logic             cen_en_q;
  logic             century_q;
  logic             hund_pulse;
  logic [7:0]       date_hi;
  logic [7:0]       hi    [NFLD];
  logic [7:0]       fq    [NFLD];
  logic [NFLD-1:0]  carry;

  tod_divider #(.TICK_HZ(TICK_HZ), .STEP(SUB_STEPS)) u_div (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (wr_en),
    .tick_i (tick),
    .run_i  (~halt_q & ~wr_en),
    .pulse_o(hund_pulse)
  );

  assign date_hi = month_len(fq[6], leap_yr(fq[I_YEAR]));

  for (genvar g = 0; g < NFLD; g++) begin : g_fld
    localparam int SRC = fld_src(g);
    logic inc;
    if (SRC < 0) begin : g_root
      assign inc = hund_pulse;
    end else begin : g_link
      assign inc = carry[SRC];
    end
    if (g == I_DATE) begin : g_dyn
      assign hi[g] = date_hi;
    end else begin : g_fix
      assign hi[g] = fld_hi(g);
    end
    tod_field #(.LO(fld_lo(g)), .MASK(fld_mask(g))) u_f (
      .clk    (clk),
      .rst    (rst),
      .inc_i  (inc),
      .ld_i   (wr_en && (g == 0 || wr_addr == 3'(g))),
      .ld_d_i (wr_data),
      .hi_i   (hi[g]),
      .q_o    (fq[g]),
      .carry_o(carry[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_q    <= 1'b0;
      cen_en_q  <= 1'b0;
      century_q <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == 3'(A_SEC)) halt_q <= wr_data[7];
      if (wr_addr == 3'(A_HOUR)) begin
        cen_en_q  <= wr_data[7];
        century_q <= wr_data[6];
      end
    end else if (carry[I_YEAR] && cen_en_q) begin
      century_q <= ~century_q;
    end
  end

  assign hund_o  = fq[0];
  assign sec_o   = {halt_q, fq[1][6:0]};
  assign min_o   = fq[2];
  assign hour_o  = {cen_en_q, century_q, fq[3][5:0]};
  assign wday_o  = {5'd0, fq[4][2:0]};
  assign date_o  = fq[5];
  assign month_o = fq[6];
  assign year_o  = fq[7];

  logic [13:0] unused_bits;
  assign unused_bits = {fq[1][7], fq[3][7:6], fq[4][7:3], carry[4], SUB_STEPS[4:0]};
endmodule

// File: rtl/tod_chain_chk.sv
module tod_chain_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic [7:0] wr_data,
  input logic [7:0] hund_o,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [7:0] wday_o,
  input logic [7:0] date_o,
  input logic [7:0] month_o,
  input logic [7:0] year_o
);
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_en) |=> $stable({hund_o, sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o}));

  p_hund_clear_r3: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (hund_o == 8'h00));

  p_min_load_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 3'd2) |=> (min_o == {1'b0, $past(wr_data[6:0])}));

  p_halt_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (sec_o[7] && !wr_en) |=> $stable({hund_o, sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o}));

  p_cent_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !hour_o[7]) |=> $stable(hour_o[6]));

  p_cent_flip_r7: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && hour_o[7]) |=>
      ((hour_o[6] != $past(hour_o[6])) == ($past(year_o) == 8'h99 && year_o == 8'h00)));

  p_wday_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && wday_o == 8'h07) |=> (wday_o == 8'h07 || wday_o == 8'h01));
endmodule

bind tod_chain tod_chain_chk u_chk (
  .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .hund_o(hund_o), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
  .date_o(date_o), .month_o(month_o), .year_o(year_o)
);

// File: tb/sim_tod_chain.sv
module sim_tod_chain;
  localparam int TPS = 250;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] hund_o, sec_o, min_o, hour_o, wday_o, date_o, month_o, year_o;

  int    total = 0;
  int    bad   = 0;
  bit    done  = 0;
  string cur_req = "R1";

  // reference state
  int         m_acc;
  logic [7:0] m_f [8];
  bit         m_halt, m_cen, m_cb;

  always #10 clk = ~clk;

  tod_chain #(.TICK_HZ(TPS)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hund_o(hund_o), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
    .date_o(date_o), .month_o(month_o), .year_o(year_o)
  );

  function automatic logic [7:0] binc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return v + 8'd1;
  endfunction

  function automatic logic [7:0] tobcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic logic [7:0] mlen(input logic [7:0] mo, input logic [7:0] y);
    int yb = int'(y[7:4]) * 10 + int'(y[3:0]);
    case (mo)
      8'h02: return (yb % 4 == 0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] lo_of(input int i);
    return (i >= 4 && i <= 6) ? 8'h01 : 8'h00;
  endfunction

  function automatic logic [7:0] hi_of(input int i);
    case (i)
      0, 7: return 8'h99;
      1, 2: return 8'h59;
      3:    return 8'h23;
      4:    return 8'h07;
      5:    return mlen(m_f[6], m_f[7]);
      default: return 8'h12;
    endcase
  endfunction

  function automatic bit bump(input int i);
    if (m_f[i] >= hi_of(i)) begin m_f[i] = lo_of(i); return 1'b1; end
    m_f[i] = binc(m_f[i]);
    return 1'b0;
  endfunction

  task automatic m_step(input bit r, input bit t, input bit w, input logic [2:0] a, input logic [7:0] d);
    if (r) begin
      m_acc = 0; m_halt = 0; m_cen = 0; m_cb = 0;
      for (int i = 0; i < 8; i++) m_f[i] = lo_of(i);
    end else if (w) begin
      case (a)
        3'd1: begin m_f[1] = d & 8'h7F; m_halt = d[7]; end
        3'd2: m_f[2] = d & 8'h7F;
        3'd3: begin m_f[3] = d & 8'h3F; m_cen = d[7]; m_cb = d[6]; end
        3'd4: m_f[4] = d & 8'h07;
        3'd5: m_f[5] = d & 8'h3F;
        3'd6: m_f[6] = d & 8'h1F;
        3'd7: m_f[7] = d;
        default: ;
      endcase
      m_f[0] = 8'h00; m_acc = 0;
    end else if (t && !m_halt) begin
      m_acc += 100;
      if (m_acc >= TPS) begin
        m_acc -= TPS;
        if (bump(0) && bump(1) && bump(2) && bump(3)) begin
          void'(bump(4));
          if (bump(5) && bump(6) && bump(7) && m_cen) m_cb = !m_cb;
        end
      end
    end
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cmp_all();
    chk({cur_req, " hund"},  hund_o,  m_f[0]);
    chk({cur_req, " sec"},   sec_o,   {m_halt, m_f[1][6:0]});
    chk({cur_req, " min"},   min_o,   m_f[2]);
    chk({cur_req, " hour"},  hour_o,  {m_cen, m_cb, m_f[3][5:0]});
    chk({cur_req, " wday"},  wday_o,  m_f[4]);
    chk({cur_req, " date"},  date_o,  m_f[5]);
    chk({cur_req, " month"}, month_o, m_f[6]);
    chk({cur_req, " year"},  year_o,  m_f[7]);
  endtask

  task automatic cyc(input bit t, input bit w, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    tick = t; wr_en = w; wr_addr = a; wr_data = d;
    @(posedge clk);
    m_step(rst, t, w, a, d);
    #2;
    cmp_all();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 3'd0, 8'h00);
  endtask

  task automatic load(input logic [7:0] s, mi, h, wd, dt, mo, y);
    cyc(1'b0, 1'b1, 3'd1, s);  cyc(1'b0, 1'b1, 3'd2, mi);
    cyc(1'b0, 1'b1, 3'd3, h);  cyc(1'b0, 1'b1, 3'd4, wd);
    cyc(1'b0, 1'b1, 3'd6, mo); cyc(1'b0, 1'b1, 3'd7, y);
    cyc(1'b0, 1'b1, 3'd5, dt);
  endtask

  function automatic logic [7:0] rnd_data(input logic [2:0] a);
    bit nearmax = ($urandom % 2) == 0;
    case (a)
      3'd1: return {($urandom % 8) == 0, 7'(tobcd(nearmax ? 55 + $urandom % 5 : $urandom % 60))};
      3'd2: return tobcd(nearmax ? 59 : $urandom % 60);
      3'd3: return {2'($urandom % 4), 6'(tobcd(nearmax ? 23 : $urandom % 24))};
      3'd4: return 8'(1 + $urandom % 7);
      3'd5: return tobcd(nearmax ? 28 : 1 + $urandom % 28);
      3'd6: return tobcd(1 + $urandom % 12);
      3'd7: return tobcd(nearmax ? 99 : $urandom % 100);
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    #(20 * 180000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd51423));
    rst = 1'b1;
    cur_req = "R1";
    repeat (3) cyc(1'b0, 1'b0, 3'd0, 8'h00);
    rst = 1'b0;
    cyc(1'b0, 1'b0, 3'd0, 8'h00);
    chk("R1 reset wday", wday_o, 8'h01);
    chk("R1 reset hour", hour_o, 8'h00);

    // fractional divider: steps at ticks 3,5,8,10
    cur_req = "R2";
    run(2);  chk("R2 before first step", hund_o, 8'h00);
    run(1);  chk("R2 first step at tick 3", hund_o, 8'h01);
    run(2);  chk("R2 second step at tick 5", hund_o, 8'h02);
    run(5);  chk("R2 fourth step at tick 10", hund_o, 8'h04);
    repeat (5) cyc(1'b0, 1'b0, 3'd0, 8'h00);
    chk("R2 no tick holds", hund_o, 8'h04);

    cur_req = "R3";
    cyc(1'b0, 1'b1, 3'd0, 8'h55);
    chk("R3 addr0 write clears hund", hund_o, 8'h00);
    run(2);  chk("R3 divider restarted", hund_o, 8'h00);
    run(1);  chk("R3 first step after write", hund_o, 8'h01);

    cur_req = "R4";
    cyc(1'b0, 1'b1, 3'd3, 8'hD7);
    chk("R4 hour byte readback", hour_o, 8'hD7);
    cyc(1'b0, 1'b1, 3'd4, 8'hFD);
    chk("R4 wday masked", wday_o, 8'h05);

    cur_req = "R8 R9";
    load(8'h59, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h23);
    run(TPS);
    chk("R8 wday wraps to 1", wday_o, 8'h01);
    chk("R9 common Feb -> Mar 01", {date_o[3:0], month_o[3:0]}, 8'h13);
    chk("R6 hours wrap", hour_o, 8'h00);

    load(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24);
    run(TPS);
    chk("R9 leap Feb 29", date_o, 8'h29);
    load(8'h59, 8'h59, 8'h23, 8'h02, 8'h29, 8'h02, 8'h24);
    run(TPS);
    chk("R9 leap Feb 29 -> Mar", month_o, 8'h03);
    load(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h24);
    run(TPS);
    chk("R9 Apr 30 -> May", month_o, 8'h05);
    chk("R8 wday advances", wday_o, 8'h03);

    cur_req = "R7";
    load(8'h59, 8'h59, 8'hA3, 8'h03, 8'h31, 8'h12, 8'h99);
    run(TPS);
    chk("R7 century flips with enable", hour_o, 8'hC0);
    chk("R9 year wraps", year_o, 8'h00);
    load(8'h59, 8'h59, 8'h63, 8'h03, 8'h31, 8'h12, 8'h99);
    run(TPS);
    chk("R7 century holds without enable", hour_o, 8'h40);

    cur_req = "R5";
    cyc(1'b0, 1'b1, 3'd1, 8'h95);
    run(TPS + 20);
    chk("R5 halted seconds", sec_o, 8'h95);
    chk("R5 halted hund", hund_o, 8'h00);
    cyc(1'b0, 1'b1, 3'd1, 8'h15);
    run(TPS);
    chk("R5 resumed", sec_o, 8'h16);

    cur_req = "R10";
    cyc(1'b0, 1'b1, 3'd1, 8'h10);
    run(TPS - 1);
    chk("R10 hund at 99", hund_o, 8'h99);
    cyc(1'b1, 1'b1, 3'd2, 8'h30);
    chk("R10 sec not advanced", sec_o, 8'h10);
    chk("R10 min loaded", min_o, 8'h30);

    cur_req = "R6 random";
    for (int i = 0; i < 30000; i++) begin
      int r = int'($urandom % 100);
      if (r < 3) begin
        logic [2:0] a = 3'($urandom % 8);
        cyc(($urandom % 2) == 0, 1'b1, a, rnd_data(a));
      end else begin
        cyc(r < 90, 1'b0, 3'd0, 8'h00);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule